// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sits on the host side of a double-buffered serial DAC and turns a code handed over on a valid/ready handshake into the DAC's serial waveforms. It drives a serial clock, a serial data line, an active-low load strobe and an active-low clear. Each waveform is timed from the system clock, and every interval is a cycle count derived at elaboration from a nanosecond minimum and the system clock period.

Each write sends a 16-bit frame, most significant bit first, with the code right-justified and the unused leading bits driven low. The load strobe stays high while the frame is shifted. After the last bit it is pulsed low, which moves the received word into the DAC's output register. A separate clear request produces a low pulse on the clear line. If the request arrives while a write is in flight, it is held and served once the load strobe has returned high.

The state machine has seven named states:
- IDLE: waiting.
- LEAD: data set up before the first clock edge.
- HIGH: serial clock high.
- LOW: serial clock low.
- TAIL: gap from the last clock edge to the strobe.
- STROBE: load strobe low.
- CLEAR: clear line low.

Its transitions are:
- IDLE→LEAD on an accepted code.
- IDLE→CLEAR on a new or pending clear request when no code is accepted.
- LEAD→HIGH, LOW→HIGH, TAIL→STROBE and CLEAR→IDLE when the state's timer expires.
- HIGH→LOW when the timer expires and bits remain.
- HIGH→TAIL when the timer expires after the sixteenth bit.
- STROBE→CLEAR when the timer expires and a clear is pending.
- STROBE→IDLE when the timer expires and no clear is pending.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: After reset the serial clock is low, the load strobe and clear are high, and ready is high.
- R2: A frame is 16 bits sent MSB first. The code occupies the low CODE_W bits of the frame, and the leading 16-CODE_W bits are driven 0.
- R3: Every write produces exactly 16 rising serial clock edges, and the load strobe is high at each of them.
- R4: The load strobe goes low only after at least ceil(40 ns/period) cycles from the last rising clock edge, and then stays low for at least ceil(30 ns/period) cycles before returning high.
- R5: The serial clock stays high for at least ceil(50 ns/period) cycles and low for at least ceil(50 ns/period) cycles. Data changes only while the clock is low, at least ceil(10 ns/period) cycles before a rising edge and at least ceil(30 ns/period) cycles after one.
- R6: A rising clock edge comes at least ceil(30 ns/period) cycles after the load strobe last rose.
- R7: Ready drops in the cycle after a code is accepted and stays low until the load strobe has returned high. Changes on the code input during that time do not alter the frame being sent.
- R8: A clear request in idle drives clear low for at least ceil(15 ns/period) cycles. While clear is low the load strobe is high and the serial clock is low.
- R9: A clear request made during a write, or in the same cycle a code is accepted, is served only after that write's load strobe has returned high. The write is delivered intact.
- R10: With CODE_W=10 the frame carries 6 leading zero bits ahead of the 10-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Code offered |
| wr_ready | output | 1 | Controller can accept a code |
| wr_code | input | CODE_W | Code to write |
| clr_req | input | 1 | One-cycle request for a clear pulse |
| dac_sck | output | 1 | Serial clock to the DAC |
| dac_sdo | output | 1 | Serial data to the DAC |
| dac_ld_n | output | 1 | Active-low load strobe |
| dac_clr_n | output | 1 | Active-low clear |

## Verification
The 12-bit instance is driven with several codes:
- All zeros and all ones, which separate a frame that is sent from one that is lost.
- Alternating patterns and the two codes either side of midscale, which expose bit-order and off-by-one shift faults.
- The single-LSB code, which shows right-justification.

A bench-side model of the DAC's shift and output registers decodes the pins and measures every interval against the nanosecond minimums. A second instance with a 10-bit code checks the padding variant. Clear requests are issued in idle, in the middle of a frame, and in the same cycle as an accepted code. These three cases show whether the clear is deferred and whether a write in flight survives it. Back-to-back writes with valid held high test the spacing between the strobe and the next clock edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_STROBE,
        ST_CLEAR
    } wr_state_e;

    // Whole system-clock cycles covering a minimum time, never less than one.
    function automatic int cyc_of(input int ns, input int per);
        int c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdac_tmr.sv
module sdac_tmr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int CODE_W  = 12,
    parameter int FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CODE_W-1:0] code,
    output logic              sdo,
    output logic              last_bit
);

    localparam int PAD_W = FRAME_W - CODE_W;
    localparam int BCW   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame_in;
    logic [FRAME_W-1:0] sreg;
    logic [BCW-1:0]     bcnt;

    generate
        if (PAD_W > 0) begin : g_pad
            assign frame_in = {{PAD_W{1'b0}}, code};
        end else begin : g_nopad
            assign frame_in = code;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            bcnt <= '0;
        end else if (load) begin
            sreg <= frame_in;
            bcnt <= '0;
        end else if (shift) begin
            sreg <= {sreg[FRAME_W-2:0], 1'b0};
            bcnt <= bcnt + 1'b1;
        end
    end

    assign sdo      = sreg[FRAME_W-1];
    assign last_bit = (bcnt == BCW'(FRAME_W - 1));

endmodule

// File: rtl/sdac_wr_ctrl.sv
module sdac_wr_ctrl
    import sdac_pkg::*;
#(
    parameter int CODE_W        = 12,
    parameter int FRAME_W       = 16,
    parameter int CLK_NS        = 20,
    parameter int SCK_HIGH_NS   = 50,
    parameter int SCK_LOW_NS    = 50,
    parameter int DATA_SETUP_NS = 10,
    parameter int DATA_HOLD_NS  = 30,
    parameter int LD_WIDTH_NS   = 30,
    parameter int LD_TO_SCK_NS  = 30,
    parameter int SCK_TO_LD_NS  = 40,
    parameter int CLR_WIDTH_NS  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              clr_req,
    output logic              dac_sck,
    output logic              dac_sdo,
    output logic              dac_ld_n,
    output logic              dac_clr_n
);

    // Data moves on the falling edge, so the high phase also covers hold
    // and the low phase also covers setup.
    localparam int HI_CYC   = max2(cyc_of(SCK_HIGH_NS, CLK_NS), cyc_of(DATA_HOLD_NS, CLK_NS));
    localparam int LO_CYC   = max2(cyc_of(SCK_LOW_NS, CLK_NS), cyc_of(DATA_SETUP_NS, CLK_NS));
    localparam int LEAD_CYC = max2(cyc_of(LD_TO_SCK_NS, CLK_NS), LO_CYC);
    localparam int TAIL_CYC = max2(cyc_of(SCK_TO_LD_NS, CLK_NS), LO_CYC);
    localparam int LDW_CYC  = cyc_of(LD_WIDTH_NS, CLK_NS);
    localparam int CLRW_CYC = cyc_of(CLR_WIDTH_NS, CLK_NS);
    localparam int MAX_CYC  = max2(max2(max2(HI_CYC, LO_CYC), max2(LEAD_CYC, TAIL_CYC)),
                                   max2(LDW_CYC, CLRW_CYC));
    localparam int TMR_W    = $clog2(MAX_CYC + 1);

    wr_state_e        state, state_nx;
    logic             clr_pend, clr_pend_nx;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             load_frame, shift_bit, last_bit;
    logic             clr_want;

    sdac_tmr #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sdac_shift #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_frame),
        .shift    (shift_bit),
        .code     (wr_code),
        .sdo      (dac_sdo),
        .last_bit (last_bit)
    );

    assign clr_want = clr_pend || clr_req;

    // Next state and datapath strobes.
    always_comb begin
        state_nx   = state;
        load_frame = 1'b0;
        shift_bit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_valid && wr_ready) begin
                    state_nx   = ST_LEAD;
                    load_frame = 1'b1;
                end else if (clr_want) begin
                    state_nx = ST_CLEAR;
                end
            end
            ST_LEAD:   if (tmr_exp) state_nx = ST_HIGH;
            ST_HIGH: begin
                if (tmr_exp) begin
                    shift_bit = 1'b1;
                    state_nx  = last_bit ? ST_TAIL : ST_LOW;
                end
            end
            ST_LOW:    if (tmr_exp) state_nx = ST_HIGH;
            ST_TAIL:   if (tmr_exp) state_nx = ST_STROBE;
            ST_STROBE: if (tmr_exp) state_nx = clr_want ? ST_CLEAR : ST_IDLE;
            ST_CLEAR:  if (tmr_exp) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Duration of the state being entered.
    always_comb begin
        tmr_load = (state_nx != state);
        unique case (state_nx)
            ST_LEAD:   tmr_val = TMR_W'(LEAD_CYC - 1);
            ST_HIGH:   tmr_val = TMR_W'(HI_CYC - 1);
            ST_LOW:    tmr_val = TMR_W'(LO_CYC - 1);
            ST_TAIL:   tmr_val = TMR_W'(TAIL_CYC - 1);
            ST_STROBE: tmr_val = TMR_W'(LDW_CYC - 1);
            ST_CLEAR:  tmr_val = TMR_W'(CLRW_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    // A request arriving during a clear merges into it.
    assign clr_pend_nx = (clr_pend || (clr_req && state != ST_CLEAR))
                         && !(state_nx == ST_CLEAR && state != ST_CLEAR);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            clr_pend <= 1'b0;
        end else begin
            state    <= state_nx;
            clr_pend <= clr_pend_nx;
        end
    end

    // Registered outputs, decoded from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_sck   <= 1'b0;
            dac_ld_n  <= 1'b1;
            dac_clr_n <= 1'b1;
            wr_ready  <= 1'b1;
        end else begin
            dac_sck   <= (state_nx == ST_HIGH);
            dac_ld_n  <= (state_nx != ST_STROBE);
            dac_clr_n <= (state_nx != ST_CLEAR);
            wr_ready  <= (state_nx == ST_IDLE) && !clr_pend_nx;
        end
    end

endmodule

// File: rtl/sdac_wr_ctrl_chk.sv
module sdac_wr_ctrl_chk #(
    parameter int LDW_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic wr_ready,
    input logic dac_sck,
    input logic dac_sdo,
    input logic dac_ld_n,
    input logic dac_clr_n
);

    logic [7:0] ld_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 ld_low_cnt <= '0;
        else if (dac_ld_n)          ld_low_cnt <= '0;
        else if (ld_low_cnt != '1)  ld_low_cnt <= ld_low_cnt + 1'b1;
    end

    // R3
    sck_under_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sck |-> dac_ld_n);

    // R4
    ld_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_ld_n) |-> (ld_low_cnt >= 8'(LDW_CYC)));

    // R5
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_sck && $past(dac_sck)) |-> $stable(dac_sdo));

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    // R8
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> (dac_ld_n && !dac_sck));

    // R9
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_clr_n) |-> dac_ld_n);

endmodule

bind sdac_wr_ctrl sdac_wr_ctrl_chk #(.LDW_CYC(LDW_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .dac_sck   (dac_sck),
    .dac_sdo   (dac_sdo),
    .dac_ld_n  (dac_ld_n),
    .dac_clr_n (dac_clr_n)
);

// File: tb/tb_sdac_wr_ctrl.sv
// Pin-level model of the DAC plus interval measurement, sampled on falling clk.
module sdac_mon #(
    parameter int CODE_W = 12
) (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic sdo,
    input logic ld_n,
    input logic clr_n
);
    localparam int P        = 20;
    localparam int HI_MIN   = (50 + P - 1) / P;
    localparam int LO_MIN   = (50 + P - 1) / P;
    localparam int DS_MIN   = (10 + P - 1) / P;
    localparam int DH_MIN   = (30 + P - 1) / P;
    localparam int LDW_MIN  = (30 + P - 1) / P;
    localparam int LD1_MIN  = (30 + P - 1) / P;
    localparam int LD2_MIN  = (40 + P - 1) / P;
    localparam int CLRW_MIN = (15 + P - 1) / P;

    logic psck, psdo, pld, pclr;
    int hi_run, lo_run, ldl_run, clrl_run, sdo_run, since_ldr, since_sckr, edges;
    logic [15:0] shreg, last_frame;
    logic [CODE_W-1:0] dac_reg, last_load;
    int last_edges, loads, checks, bad;

    task automatic mchk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s (CODE_W=%0d) actual=%0d expected=%0d", tag, CODE_W, act, exp);
        end
    endtask

    initial begin
        checks = 0; bad = 0; loads = 0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            psck = 0; psdo = 0; pld = 1; pclr = 1;
            hi_run = 0; lo_run = 0; ldl_run = 0; clrl_run = 0; sdo_run = 0;
            since_ldr = 1000; since_sckr = 1000; edges = 0;
            shreg = '0; last_frame = '0; dac_reg = '0; last_load = '0; last_edges = 0;
        end else begin
            since_ldr++;
            since_sckr++;
            if (sck && !psck) begin
                mchk(ld_n, "R3 strobe high at rising sck", int'(ld_n), 1);
                mchk(since_ldr >= LD1_MIN, "R6 strobe rise to sck rise", since_ldr, LD1_MIN);
                if (edges > 0) mchk(lo_run >= LO_MIN, "R5 sck low width", lo_run, LO_MIN);
                mchk(sdo_run - 1 >= DS_MIN, "R5 data setup", sdo_run - 1, DS_MIN);
                if (ld_n) shreg = {shreg[14:0], sdo};
                edges++;
                since_sckr = 0;
            end
            if (!sck && psck) begin
                mchk(hi_run >= HI_MIN, "R5 sck high width", hi_run, HI_MIN);
                mchk(hi_run >= DH_MIN, "R5 data hold", hi_run, DH_MIN);
            end
            if (sck && psck && sdo != psdo)
                mchk(1'b0, "R5 data moved while sck high", int'(sdo), int'(psdo));
            if (!ld_n && pld) begin
                mchk(since_sckr >= LD2_MIN, "R4 last sck rise to strobe", since_sckr, LD2_MIN);
                last_frame = shreg;
                last_edges = edges;
                edges = 0;
                dac_reg = shreg[CODE_W-1:0];
                last_load = shreg[CODE_W-1:0];
                loads++;
            end
            if (ld_n && !pld) begin
                mchk(ldl_run >= LDW_MIN, "R4 strobe low width", ldl_run, LDW_MIN);
                since_ldr = 0;
            end
            if (!clr_n) begin
                mchk(ld_n && !sck, "R8 quiet during clear", int'({ld_n, sck}), 2);
                dac_reg = '0;
            end
            if (clr_n && !pclr)
                mchk(clrl_run >= CLRW_MIN, "R8 clear width", clrl_run, CLRW_MIN);
            hi_run   = sck ? (psck ? hi_run + 1 : 1) : 0;
            lo_run   = !sck ? (!psck ? lo_run + 1 : 1) : 0;
            ldl_run  = !ld_n ? (!pld ? ldl_run + 1 : 1) : 0;
            clrl_run = !clr_n ? (!pclr ? clrl_run + 1 : 1) : 0;
            sdo_run  = (sdo == psdo) ? sdo_run + 1 : 1;
            psck = sck; psdo = sdo; pld = ld_n; pclr = clr_n;
        end
    end
endmodule

module tb_sdac_wr_ctrl;
    logic clk = 0;
    logic rst_n = 0;
    always #10 clk = ~clk;

    logic        v12 = 0, clr12 = 0, r12, sck12, sdo12, ld12, cl12;
    logic [11:0] c12 = '0;
    logic        v10 = 0, clr10 = 0, r10, sck10, sdo10, ld10, cl10;
    logic [9:0]  c10 = '0;

    int total = 0, bad = 0;
    bit ended = 0;

    sdac_wr_ctrl #(.CODE_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(v12), .wr_ready(r12), .wr_code(c12),
        .clr_req(clr12), .dac_sck(sck12), .dac_sdo(sdo12), .dac_ld_n(ld12), .dac_clr_n(cl12));

    sdac_wr_ctrl #(.CODE_W(10)) dut_b (
        .clk(clk), .rst_n(rst_n), .wr_valid(v10), .wr_ready(r10), .wr_code(c10),
        .clr_req(clr10), .dac_sck(sck10), .dac_sdo(sdo10), .dac_ld_n(ld10), .dac_clr_n(cl10));

    sdac_mon #(.CODE_W(12)) mon12 (.clk(clk), .rst_n(rst_n), .sck(sck12), .sdo(sdo12), .ld_n(ld12), .clr_n(cl12));
    sdac_mon #(.CODE_W(10)) mon10 (.clk(clk), .rst_n(rst_n), .sck(sck10), .sdo(sdo10), .ld_n(ld10), .clr_n(cl10));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            total += mon12.checks + mon10.checks;
            bad   += mon12.bad + mon10.bad;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_ready12();
        while (!r12) @(negedge clk);
    endtask

    task automatic accept12(input logic [11:0] c);
        @(negedge clk);
        c12 = c; v12 = 1;
        while (!r12) @(negedge clk);
        @(negedge clk);
        v12 = 0;
    endtask

    task automatic t_reset();
        chk(r12 && !sck12 && ld12 && cl12, "R1 reset state 12-bit", int'({r12, sck12, ld12, cl12}), 4'b1011);
        chk(r10 && !sck10 && ld10 && cl10, "R1 reset state 10-bit", int'({r10, sck10, ld10, cl10}), 4'b1011);
    endtask

    task automatic t_write12(input logic [11:0] c);
        int l0;
        l0 = mon12.loads;
        accept12(c);
        wait_ready12();
        @(negedge clk);
        chk(mon12.loads == l0 + 1, "R7 one frame per accept", mon12.loads - l0, 1);
        chk(mon12.dac_reg == c, "R2 DAC register after write", int'(mon12.dac_reg), int'(c));
        chk(mon12.last_frame == {4'b0, c}, "R2 frame with zero padding", int'(mon12.last_frame), int'({4'b0, c}));
        chk(mon12.last_edges == 16, "R3 rising edges per frame", mon12.last_edges, 16);
    endtask

    task automatic t_write10(input logic [9:0] c);
        int l0;
        l0 = mon10.loads;
        @(negedge clk);
        c10 = c; v10 = 1;
        while (!r10) @(negedge clk);
        @(negedge clk);
        v10 = 0;
        while (!r10) @(negedge clk);
        @(negedge clk);
        chk(mon10.loads == l0 + 1, "R10 one frame per accept", mon10.loads - l0, 1);
        chk(mon10.last_frame == {6'b0, c}, "R10 10-bit frame padding", int'(mon10.last_frame), int'({6'b0, c}));
        chk(mon10.dac_reg == c, "R10 DAC register", int'(mon10.dac_reg), int'(c));
        chk(mon10.last_edges == 16, "R10 rising edges per frame", mon10.last_edges, 16);
    endtask

    task automatic t_busy12(input logic [11:0] a, input logic [11:0] b);
        int hi;
        bit seen_low;
        hi = 0; seen_low = 0;
        accept12(a);
        c12 = b;
        while (!(seen_low && ld12)) begin
            if (!ld12) seen_low = 1;
            if (r12) hi++;
            @(negedge clk);
        end
        chk(hi == 0, "R7 ready low until strobe returns", hi, 0);
        chk(r12, "R7 ready back with strobe", int'(r12), 1);
        chk(mon12.dac_reg == a, "R7 code change while busy ignored", int'(mon12.dac_reg), int'(a));
    endtask

    task automatic t_clear_idle12();
        int l0;
        l0 = mon12.loads;
        @(negedge clk); clr12 = 1;
        @(negedge clk); clr12 = 0;
        chk(!cl12, "R8 clear pulse starts", int'(cl12), 0);
        wait_ready12();
        @(negedge clk);
        chk(mon12.dac_reg == 0, "R8 DAC register cleared", int'(mon12.dac_reg), 0);
        chk(mon12.loads == l0, "R8 no strobe during clear", mon12.loads - l0, 0);
    endtask

    task automatic t_clear_mid12(input logic [11:0] c);
        int l0;
        l0 = mon12.loads;
        accept12(c);
        repeat (20) @(negedge clk);
        clr12 = 1;
        @(negedge clk); clr12 = 0;
        chk(cl12, "R9 clear held while shifting", int'(cl12), 1);
        while (cl12) @(negedge clk);
        chk(mon12.loads == l0 + 1, "R9 write strobed before clear", mon12.loads - l0, 1);
        chk(mon12.last_load == c, "R9 write intact before clear", int'(mon12.last_load), int'(c));
        wait_ready12();
        @(negedge clk);
        chk(mon12.dac_reg == 0, "R9 cleared after write", int'(mon12.dac_reg), 0);
    endtask

    task automatic t_same_cycle12(input logic [11:0] c);
        int l0;
        l0 = mon12.loads;
        wait_ready12();
        @(negedge clk);
        c12 = c; v12 = 1; clr12 = 1;
        @(negedge clk);
        v12 = 0; clr12 = 0;
        chk(!r12 && cl12, "R9 write taken first", int'({r12, cl12}), 1);
        while (cl12) @(negedge clk);
        chk(mon12.loads == l0 + 1 && mon12.last_load == c, "R9 simultaneous write delivered",
            int'(mon12.last_load), int'(c));
        wait_ready12();
        @(negedge clk);
        chk(mon12.dac_reg == 0, "R9 clear after simultaneous write", int'(mon12.dac_reg), 0);
    endtask

    task automatic t_b2b12(input logic [11:0] d1, input logic [11:0] d2);
        int l0;
        l0 = mon12.loads;
        @(negedge clk);
        c12 = d1; v12 = 1;
        while (!r12) @(negedge clk);
        @(negedge clk);
        c12 = d2;
        while (!r12) @(negedge clk);
        @(negedge clk);
        v12 = 0;
        wait_ready12();
        @(negedge clk);
        chk(mon12.loads == l0 + 2, "R6 back-to-back frames", mon12.loads - l0, 2);
        chk(mon12.dac_reg == d2, "R6 second frame value", int'(mon12.dac_reg), int'(d2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write12(12'h000);
        t_write12(12'hFFF);
        t_write12(12'hA5C);
        t_write12(12'h800);
        t_write12(12'h7FF);
        t_write12(12'h001);
        t_busy12(12'h3C6, 12'hC39);
        t_clear_idle12();
        t_write12(12'h5A5);
        t_clear_mid12(12'h9B4);
        t_same_cycle12(12'h123);
        t_b2b12(12'hE01, 12'h1FE);
        t_write10(10'h3FF);
        t_write10(10'h155);
        t_write10(10'h2AA);
        t_write10(10'h000);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule